// File: doc/BRIEF.md
# Edge-Triggered Interrupt Flag Controller

This block gathers interrupt events for a clock-control peripheral. It watches a parameterized set of status inputs, one per event source (oscillator ready, clock failure, loop lock gained or lost, lock timeout, ratio update done, and so on). A rising edge on a source captures a sticky flag. The block drives one shared interrupt request, and software reads the flag register to find out which sources are pending.

Software reaches the block through a small synchronous register bus with three registers. The first is a pending-flag register that is cleared by writing ones. The second is an enable register that is set by writing ones. The third is an enable register that is cleared by writing ones. Both enable registers read back the same enable mask. The request output is high while any flag has its enable bit set, but only when the global interrupt enable input is high.

Top module: `evt_irq_ctrl`

## Requirements
- R1: A 0-to-1 change on status input i sets flag bit i at the first rising clock edge that sees the new value. A status input that stays high does not set the flag again after software has cleared it.
- R2: Register map on the 2-bit address: 0 is the flag register, 1 is the enable-set register, 2 is the enable-clear register, and 3 is unused. Bit i of each register belongs to source i. Reads are combinational. Addresses 1 and 2 both return the enable mask. Address 3 reads zero and ignores writes. Read-data bits at NUM_SRC and above are zero.
- R3: A write to address 1 enables every source whose data bit is 1. Bits written as 0 leave their enables unchanged.
- R4: A write to address 2 disables every source whose data bit is 1. Bits written as 0 leave their enables unchanged. A write to address 2 does not change any flag.
- R5: With the global enable high, `irq_o` is high exactly when some source has both its flag and its enable set. The request persists until that flag is cleared or that source is disabled.
- R6: A write to address 0 clears every flag whose data bit is 1. Bits written as 0 leave their flags unchanged.
- R7: When a rising edge on a source and a clear of that source's flag happen in the same cycle, the flag ends up set.
- R8: While `gie_i` is low, `irq_o` is low, whatever the flags and enables are.
- R9: Synchronous active-low reset clears all flags, all enables and the stored previous status. A status input that is high when reset is released therefore sets its flag at the first clock edge after release.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Synchronous reset, active low |
| status_i | input | NUM_SRC | Status level of each event source |
| gie_i | input | 1 | Global interrupt enable |
| bus_sel_i | input | 1 | Register access in this cycle |
| bus_wr_i | input | 1 | 1 = write, 0 = read |
| bus_addr_i | input | 2 | Register address |
| bus_wdata_i | input | DATA_W | Write data |
| bus_rdata_o | output | DATA_W | Read data for the addressed register |
| irq_o | output | 1 | Combined interrupt request |

## Verification
Two situations are the hardest to reach from the ports. The first is a clear of a flag that falls in the same clock cycle as a new rising edge on that flag's source. The bench first lets the flag be captured and the source drop again. It then raises the source and issues the clearing write at the same falling edge. A neighbouring flag in the same write is expected to clear normally. The second situation is a status input held high across reset. The bench checks that the flag is captured right after release, because the stored previous status has been wiped. Request gating is then swept over all eight flag, enable and global-enable combinations for every source.

// File: rtl/evt_irq_pkg.sv
// Package: shared register addresses for the interrupt flag controller.
// Assumes a 2-bit word address on the register bus.
package evt_irq_pkg;

    localparam int unsigned REG_ADDR_W = 2;

    typedef enum logic [REG_ADDR_W-1:0] {
        REG_FLAG   = 2'd0,
        REG_EN_SET = 2'd1,
        REG_EN_CLR = 2'd2,
        REG_SPARE  = 2'd3
    } evt_reg_e;

endpackage

// File: rtl/evt_edge_detect.sv
// Module: per-bit rising-edge detector.
// Holds each input one cycle and reports a bit as rising while the live
// value is 1 and the held value is 0. Assumes inputs are synchronous to clk_i.
module evt_edge_detect #(
    parameter int unsigned WIDTH = 10
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic [WIDTH-1:0] lvl_i,
    output logic [WIDTH-1:0] rise_o
);

    logic [WIDTH-1:0] hold_q;

    for (genvar gi = 0; gi < WIDTH; gi++) begin : g_bit
        // Keep the previous level of this source.
        always_ff @(posedge clk_i) begin
            if (!rst_ni) hold_q[gi] <= 1'b0;
            else         hold_q[gi] <= lvl_i[gi];
        end

        // Report a 0-to-1 change.
        always_comb rise_o[gi] = lvl_i[gi] & ~hold_q[gi];
    end

endmodule

// File: rtl/evt_flag_bank.sv
// Module: sticky pending flags.
// A set pulse wins over a clear pulse in the same cycle. Assumes set_i and
// clr_i are single-cycle masks.
module evt_flag_bank #(
    parameter int unsigned WIDTH = 10
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic [WIDTH-1:0] set_i,
    input  logic [WIDTH-1:0] clr_i,
    output logic [WIDTH-1:0] flag_o
);

    logic [WIDTH-1:0] flag_q;

    for (genvar gi = 0; gi < WIDTH; gi++) begin : g_flag
        // Update one flag: set has priority over clear.
        always_ff @(posedge clk_i) begin
            if (!rst_ni)         flag_q[gi] <= 1'b0;
            else if (set_i[gi])  flag_q[gi] <= 1'b1;
            else if (clr_i[gi])  flag_q[gi] <= 1'b0;
        end
    end

    assign flag_o = flag_q;

endmodule

// File: rtl/evt_enable_bank.sv
// Module: interrupt enable mask with write-one-to-set and write-one-to-clear.
// Assumes the set and clear masks never come from the same bus cycle.
module evt_enable_bank #(
    parameter int unsigned WIDTH = 10
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic [WIDTH-1:0] set_i,
    input  logic [WIDTH-1:0] clr_i,
    output logic [WIDTH-1:0] en_o
);

    logic [WIDTH-1:0] en_q;

    // Merge set and clear masks into the stored enables.
    always_ff @(posedge clk_i) begin
        if (!rst_ni) en_q <= '0;
        else         en_q <= (en_q | set_i) & ~clr_i;
    end

    assign en_o = en_q;

endmodule

// File: rtl/evt_irq_combine.sv
// Module: reduces flags and enables to one request line, gated globally.
// Purely combinational. Assumes flags and enables are registered upstream.
module evt_irq_combine #(
    parameter int unsigned WIDTH = 10
) (
    input  logic [WIDTH-1:0] flag_i,
    input  logic [WIDTH-1:0] en_i,
    input  logic             gie_i,
    output logic             irq_o
);

    logic [WIDTH-1:0] live;

    // Sources that are both pending and enabled.
    always_comb live = flag_i & en_i;

    // One shared request line.
    always_comb irq_o = gie_i & (|live);

endmodule

// File: rtl/evt_irq_ctrl.sv
// Module: edge-triggered interrupt flag controller (top).
// Decodes the register bus, feeds the edge detector, flag bank and enable
// bank, and drives the combined request. Assumes NUM_SRC <= DATA_W and a
// synchronous single-cycle register bus; reads have no side effects.
module evt_irq_ctrl
    import evt_irq_pkg::*;
#(
    parameter int unsigned NUM_SRC = 10,
    parameter int unsigned DATA_W  = 32
) (
    input  logic                  clk_i,
    input  logic                  rst_ni,
    input  logic [NUM_SRC-1:0]    status_i,
    input  logic                  gie_i,
    input  logic                  bus_sel_i,
    input  logic                  bus_wr_i,
    input  logic [REG_ADDR_W-1:0] bus_addr_i,
    input  logic [DATA_W-1:0]     bus_wdata_i,
    output logic [DATA_W-1:0]     bus_rdata_o,
    output logic                  irq_o
);

    localparam int unsigned PAD_W = DATA_W - NUM_SRC;

    evt_reg_e         reg_sel;
    logic             wr_en;
    logic [NUM_SRC-1:0] wmask;
    logic [NUM_SRC-1:0] rise;
    logic [NUM_SRC-1:0] flag_clr;
    logic [NUM_SRC-1:0] en_set;
    logic [NUM_SRC-1:0] en_clr;
    logic [NUM_SRC-1:0] flag_q;
    logic [NUM_SRC-1:0] en_q;

    // Decode the address and the write strobe.
    always_comb begin
        reg_sel = evt_reg_e'(bus_addr_i);
        wr_en   = bus_sel_i & bus_wr_i;
        wmask   = bus_wdata_i[NUM_SRC-1:0];
    end

    // Route write masks to the addressed register only.
    always_comb begin
        flag_clr = '0;
        en_set   = '0;
        en_clr   = '0;
        if (wr_en) begin
            unique case (reg_sel)
                REG_FLAG:   flag_clr = wmask;
                REG_EN_SET: en_set   = wmask;
                REG_EN_CLR: en_clr   = wmask;
                REG_SPARE:  ;
            endcase
        end
    end

    if (PAD_W > 0) begin : g_pad
        logic unused_wdata_hi;
        // Upper write-data bits carry no sources.
        always_comb unused_wdata_hi = ^bus_wdata_i[DATA_W-1:NUM_SRC];
    end

    evt_edge_detect #(.WIDTH(NUM_SRC)) u_edge (
        .clk_i  (clk_i),
        .rst_ni (rst_ni),
        .lvl_i  (status_i),
        .rise_o (rise)
    );

    evt_flag_bank #(.WIDTH(NUM_SRC)) u_flags (
        .clk_i  (clk_i),
        .rst_ni (rst_ni),
        .set_i  (rise),
        .clr_i  (flag_clr),
        .flag_o (flag_q)
    );

    evt_enable_bank #(.WIDTH(NUM_SRC)) u_enables (
        .clk_i  (clk_i),
        .rst_ni (rst_ni),
        .set_i  (en_set),
        .clr_i  (en_clr),
        .en_o   (en_q)
    );

    evt_irq_combine #(.WIDTH(NUM_SRC)) u_combine (
        .flag_i (flag_q),
        .en_i   (en_q),
        .gie_i  (gie_i),
        .irq_o  (irq_o)
    );

    // Read multiplexer, zero-extended to the bus width.
    always_comb begin
        bus_rdata_o = '0;
        unique case (reg_sel)
            REG_FLAG:   bus_rdata_o[NUM_SRC-1:0] = flag_q;
            REG_EN_SET: bus_rdata_o[NUM_SRC-1:0] = en_q;
            REG_EN_CLR: bus_rdata_o[NUM_SRC-1:0] = en_q;
            REG_SPARE:  bus_rdata_o = '0;
        endcase
    end

endmodule

// File: rtl/evt_irq_ctrl_chk.sv
// Checker: temporal properties of the interrupt flag controller, bound to
// the top. Keeps its own copy of the previous status for edge reference.
module evt_irq_ctrl_chk #(
    parameter int unsigned NUM_SRC = 10,
    parameter int unsigned DATA_W  = 32
) (
    input logic               clk_i,
    input logic               rst_ni,
    input logic [NUM_SRC-1:0] status_i,
    input logic               gie_i,
    input logic               bus_sel_i,
    input logic               bus_wr_i,
    input logic [1:0]         bus_addr_i,
    input logic [DATA_W-1:0]  bus_wdata_i,
    input logic               irq_o,
    input logic [NUM_SRC-1:0] flag_q,
    input logic [NUM_SRC-1:0] en_q
);

    logic [NUM_SRC-1:0] prev_q;
    logic [NUM_SRC-1:0] up;
    logic [NUM_SRC-1:0] wd;
    logic [NUM_SRC-1:0] clr_vec;
    logic               wr_set;
    logic               wr_clr;

    // Independent record of last cycle's status.
    always_ff @(posedge clk_i) begin
        if (!rst_ni) prev_q <= '0;
        else         prev_q <= status_i;
    end

    always_comb begin
        up      = status_i & ~prev_q;
        wd      = bus_wdata_i[NUM_SRC-1:0];
        wr_set  = bus_sel_i && bus_wr_i && (bus_addr_i == 2'd1);
        wr_clr  = bus_sel_i && bus_wr_i && (bus_addr_i == 2'd2);
        clr_vec = (bus_sel_i && bus_wr_i && (bus_addr_i == 2'd0)) ? wd : '0;
    end

    AST_EDGE_SETS_FLAG: assert property (@(posedge clk_i) disable iff (!rst_ni) (up != '0) |=> ((flag_q & $past(up)) == $past(up))); // R1
    AST_NO_SPURIOUS_FLAG: assert property (@(posedge clk_i) disable iff (!rst_ni) 1'b1 |=> ((flag_q & ~$past(flag_q) & ~$past(up)) == '0)); // R1
    AST_FLAG_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni) 1'b1 |=> (($past(flag_q) & ~flag_q & ~$past(clr_vec)) == '0)); // R6
    AST_SET_BEATS_CLEAR: assert property (@(posedge clk_i) disable iff (!rst_ni) ((up & clr_vec) != '0) |=> ((flag_q & $past(up & clr_vec)) == $past(up & clr_vec))); // R7
    AST_ENABLE_SET: assert property (@(posedge clk_i) disable iff (!rst_ni) wr_set |=> ((en_q & $past(wd)) == $past(wd))); // R3
    AST_ENABLE_CLEAR: assert property (@(posedge clk_i) disable iff (!rst_ni) wr_clr |=> ((en_q & $past(wd)) == '0)); // R4
    AST_ENABLE_STABLE: assert property (@(posedge clk_i) disable iff (!rst_ni) (!wr_set && !wr_clr) |=> $stable(en_q)); // R4
    AST_IRQ_GATED: assert property (@(posedge clk_i) disable iff (!rst_ni) !gie_i |-> !irq_o); // R8
    AST_IRQ_HAS_SOURCE: assert property (@(posedge clk_i) disable iff (!rst_ni) irq_o |-> ((flag_q & en_q) != '0)); // R5
    AST_IRQ_RAISED: assert property (@(posedge clk_i) disable iff (!rst_ni) (gie_i && ((flag_q & en_q) != '0)) |-> irq_o); // R5
    AST_RESET_CLEARS: assert property (@(posedge clk_i) !rst_ni |=> (flag_q == '0 && en_q == '0)); // R9

endmodule

bind evt_irq_ctrl evt_irq_ctrl_chk #(
    .NUM_SRC (NUM_SRC),
    .DATA_W  (DATA_W)
) u_chk (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .status_i    (status_i),
    .gie_i       (gie_i),
    .bus_sel_i   (bus_sel_i),
    .bus_wr_i    (bus_wr_i),
    .bus_addr_i  (bus_addr_i),
    .bus_wdata_i (bus_wdata_i),
    .irq_o       (irq_o),
    .flag_q      (flag_q),
    .en_q        (en_q)
);

// File: tb/tb_evt_irq_ctrl.sv
`timescale 1ns/100ps
// Bench: scoreboard style. Driver tasks push expected values, a monitor
// process pops and compares them against the outputs at falling edges.
module tb_evt_irq_ctrl;

    localparam int N = 10;
    localparam int W = 32;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic [N-1:0] status = '0;
    logic         gie = 1'b0;
    logic         bus_sel = 1'b0;
    logic         bus_wr = 1'b0;
    logic [1:0]   bus_addr = 2'd0;
    logic [W-1:0] bus_wdata = '0;
    logic [W-1:0] bus_rdata;
    logic         irq;

    int n_checks = 0;
    int n_errs = 0;
    bit done = 1'b0;

    string        tag_q[$];
    logic [W-1:0] exp_q[$];
    bit           kind_q[$];
    event         sb_ev;
    event         sb_done;

    always #2.5 clk = ~clk;

    evt_irq_ctrl #(.NUM_SRC(N), .DATA_W(W)) dut (
        .clk_i       (clk),
        .rst_ni      (rst_n),
        .status_i    (status),
        .gie_i       (gie),
        .bus_sel_i   (bus_sel),
        .bus_wr_i    (bus_wr),
        .bus_addr_i  (bus_addr),
        .bus_wdata_i (bus_wdata),
        .bus_rdata_o (bus_rdata),
        .irq_o       (irq)
    );

    // Monitor: drain the scoreboard each time the driver posts items.
    initial begin
        forever begin
            @(sb_ev);
            while (exp_q.size() != 0) begin
                string        t;
                logic [W-1:0] e;
                logic [W-1:0] o;
                bit           k;
                t = tag_q.pop_front();
                e = exp_q.pop_front();
                k = kind_q.pop_front();
                o = k ? {{(W-1){1'b0}}, irq} : bus_rdata;
                n_checks++;
                if (o !== e) begin
                    n_errs++;
                    $display("FAIL %s actual %h expected %h", t, o, e);
                end
            end
            -> sb_done;
        end
    end

    // One clock; bus access lasts a single cycle.
    task automatic tick();
        @(posedge clk);
        @(negedge clk);
        bus_sel   = 1'b0;
        bus_wr    = 1'b0;
        bus_wdata = '0;
    endtask

    task automatic wr(input logic [1:0] a, input logic [W-1:0] d);
        bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        tick();
    endtask

    task automatic post(input string t, input logic [W-1:0] e, input bit k);
        #0.2;
        tag_q.push_back(t);
        exp_q.push_back(e);
        kind_q.push_back(k);
        -> sb_ev;
        @(sb_done);
    endtask

    task automatic chk_rd(input logic [1:0] a, input logic [W-1:0] e, input string t);
        bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a;
        post(t, e, 1'b0);
        bus_sel = 1'b0;
    endtask

    task automatic chk_irq(input bit e, input string t);
        post(t, {{(W-1){1'b0}}, e}, 1'b1);
    endtask

    // Watchdog: a hung run counts as a failure.
    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_errs++;
            $display("FAIL watchdog all requirements actual hung expected finished");
            $display("  CHECKS %0d ERRORS %0d", n_checks, n_errs);
            $finish;
        end
    end

    initial begin
        @(negedge clk);
        repeat (3) tick();
        chk_rd(2'd0, 32'h0, "R9 flags in reset");
        chk_rd(2'd1, 32'h0, "R9 enables in reset");
        chk_irq(1'b0, "R9 irq in reset");
        rst_n = 1'b1;
        tick();

        // R1: edge capture and no re-set while level holds
        status[3] = 1'b1;
        tick();
        chk_rd(2'd0, 32'h008, "R1 rising edge sets flag");
        tick(); tick();
        wr(2'd0, 32'h008);
        chk_rd(2'd0, 32'h000, "R6 write-one clears flag");
        tick(); tick();
        chk_rd(2'd0, 32'h000, "R1 held level does not re-set");
        status[3] = 1'b0;
        tick();

        // R6: zeros leave flags alone
        status[5] = 1'b1; tick(); status[5] = 1'b0; tick();
        wr(2'd0, 32'h000);
        chk_rd(2'd0, 32'h020, "R6 zero write keeps flag");

        // R3 / R2 / R5 / R8
        wr(2'd1, 32'h000);
        chk_rd(2'd1, 32'h000, "R3 zero write enables nothing");
        wr(2'd1, 32'h020);
        chk_rd(2'd1, 32'h020, "R3 enable set");
        chk_rd(2'd2, 32'h020, "R2 clear address reads mask");
        chk_irq(1'b0, "R8 gie low blocks request");
        gie = 1'b1;
        chk_irq(1'b1, "R5 request with flag and enable");
        tick(); tick();
        chk_irq(1'b1, "R5 request persists");

        // R4
        wr(2'd2, 32'h000);
        chk_rd(2'd1, 32'h020, "R4 zero write keeps enable");
        chk_irq(1'b1, "R4 request unchanged");
        wr(2'd2, 32'h020);
        chk_rd(2'd1, 32'h000, "R4 enable cleared");
        chk_irq(1'b0, "R4 disable drops request");
        chk_rd(2'd0, 32'h020, "R4 flag untouched by disable");

        // R5: clearing the flag drops the request
        wr(2'd1, 32'h020);
        chk_irq(1'b1, "R5 re-enabled request");
        wr(2'd0, 32'h020);
        chk_irq(1'b0, "R5 flag clear drops request");

        // R7: set beats clear in the same cycle
        status[2] = 1'b1; tick(); status[2] = 1'b0; tick();
        status[4] = 1'b1; tick(); status[4] = 1'b0; tick();
        chk_rd(2'd0, 32'h014, "R7 two flags pending");
        status[2] = 1'b1;
        wr(2'd0, 32'h014);
        chk_rd(2'd0, 32'h004, "R7 edge wins over clear");
        status = '0;
        tick();
        wr(2'd0, 32'h3FF);

        // R2: spare address and upper bits
        wr(2'd3, 32'hFFFF_FFFF);
        chk_rd(2'd3, 32'h000, "R2 spare address reads zero");
        chk_rd(2'd1, 32'h020, "R2 spare write leaves enables");
        chk_rd(2'd0, 32'h000, "R2 spare write leaves flags");
        wr(2'd1, 32'hFFFF_FFFF);
        chk_rd(2'd1, 32'h3FF, "R2 upper read bits zero");
        wr(2'd2, 32'hFFFF_FFFF);

        // R9: reset mid-operation with a status held high
        status[1] = 1'b1; tick(); status[1] = 1'b0; tick();
        wr(2'd1, 32'h002);
        chk_irq(1'b1, "R9 request before reset");
        status[7] = 1'b1;
        tick();
        rst_n = 1'b0;
        tick();
        chk_rd(2'd0, 32'h000, "R9 flags cleared by reset");
        chk_rd(2'd1, 32'h000, "R9 enables cleared by reset");
        rst_n = 1'b1;
        tick();
        chk_rd(2'd0, 32'h080, "R9 held status sets flag after release");
        chk_irq(1'b0, "R9 no request without enable");
        status = '0;
        tick();

        // R5 / R8: every flag, enable and global-enable combination per source
        for (int i = 0; i < N; i++) begin
            for (int c = 0; c < 8; c++) begin
                wr(2'd0, 32'h3FF);
                wr(2'd2, 32'h3FF);
                gie = c[2];
                if (c[0]) begin
                    status[i] = 1'b1; tick();
                    status[i] = 1'b0; tick();
                end
                if (c[1]) wr(2'd1, 32'h1 << i);
                chk_irq(c[0] & c[1] & c[2], $sformatf("R5 R8 src %0d combo %0d", i, c));
            end
        end

        done = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", n_checks, n_errs);
        $finish;
    end

endmodule